// File: doc/BRIEF.md
# Slow-to-Fast Scan Shift Bridge

This block carries a serial scan shift that is requested in a slow test clock domain into a fast test clock domain, where a set of register chains lives. It also returns the bit that leaves the active chain to the slow side. Scan data never crosses the boundary through its own synchronizer. Instead, each slow-domain shift request flips a toggle flag. The fast domain passes that flag through a flip-flop synchronizer and turns each change of level into a single-cycle capture strobe. The strobe then loads the slow-domain serial input into the selected chain.

The design depends on a clock ratio of at least 8:1 between the fast and slow clocks. Under that ratio, the serial input and the chain select are still steady when the strobe samples them. The strobe lands within four fast cycles of the slow edge. The bit sent back to the slow side therefore settles well before the next slow edge samples it. The chain select comes from the slow side, where an instruction decoder outside this block drives it. It is registered once in the slow domain and once more in the fast domain. The integrator should change it only while no shift is in flight.

Top module: `scan_shift_bridge`

## Requirements
- R1: While `rst` is high, and after its release until the first shift, `chain_state` is all zeros and `scan_out` and `capture_pulse` are low.
- R2: Each rising `slow_clk` edge that samples `shift_req` high produces exactly one `capture_pulse` one fast cycle wide. A slow edge that samples `shift_req` low produces none.
- R3: With the default three synchronizer stages, `capture_pulse` is high between the third and the fourth rising `fast_clk` edge after the launching slow edge. The chain changes on that fourth edge and not before.
- R4: On a capture, chain c occupies `chain_state[c*LEN +: LEN]`. The selected chain shifts one place toward bit 0, and the `scan_in` value sampled at the slow edge enters bit LEN-1.
- R5: On a capture, every chain other than the selected one keeps its contents. Without a capture, no chain changes.
- R6: After the slow edge that follows a shift, `scan_out` equals bit 0 of the selected chain as it stood just before that shift. Between shifts it holds its value.
- R7: A new `chain_sel` value sampled at a slow edge applies to a shift requested at that same edge, so consecutive shifts may target different chains.
- R8: Shifts requested on every slow edge back to back each produce their own capture, whichever direction the toggle flag moves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| slow_clk | input | 1 | Slow test clock that requests shifts |
| fast_clk | input | 1 | Fast test clock of the chains, at least 8x slow_clk |
| rst | input | 1 | Asynchronous active-high reset for both domains |
| shift_req | input | 1 | Shift request, sampled on slow_clk |
| scan_in | input | 1 | Serial input, held for the whole slow period |
| chain_sel | input | $clog2(NCHAIN) | Index of the chain the shifts act on |
| scan_out | output | 1 | Serial output, registered in the slow domain |
| capture_pulse | output | 1 | One-fast-cycle capture strobe |
| chain_state | output | NCHAIN*LEN | Contents of all chains, chain c at bits c*LEN upward |

## Verification
Suppose the toggle flag or a synchronizer stage is wrong. The capture strobe is then missing, doubled or late, and this shows on `capture_pulse` within four fast cycles of the slow edge. Suppose instead the fast copy of the chain select is stale or decoded wrongly. In that case, at the fourth fast edge the wrong slice of `chain_state` moves while the intended one stays still. A fault in the returned bit register shows on `scan_out` one slow edge after the shift. The bench samples each of these at the cycle where the correct value must first appear.

// File: rtl/scan_shift_bridge.sv
module scan_shift_bridge #(
  parameter int NCHAIN = 4,
  parameter int LEN    = 8,
  parameter int SYNC   = 3
) (
  input  logic                      slow_clk,
  input  logic                      fast_clk,
  input  logic                      rst,
  input  logic                      shift_req,
  input  logic                      scan_in,
  input  logic [$clog2(NCHAIN)-1:0] chain_sel,
  output logic                      scan_out,
  output logic                      capture_pulse,
  output logic [NCHAIN*LEN-1:0]     chain_state
);
  localparam int SW = $clog2(NCHAIN);

  logic          half_tgl;
  logic [SW-1:0] sel_slow;
  logic [SW-1:0] sel_fast;
  logic [SYNC-1:0] sync_q;
  logic          edge_ref;
  logic          out_fast;
  logic          head_bit;

  // slow domain: toggle per shift, select and returned bit
  always_ff @(posedge slow_clk or posedge rst) begin
    if (rst) begin
      half_tgl <= 1'b0;
      sel_slow <= '0;
      scan_out <= 1'b0;
    end else begin
      if (shift_req) half_tgl <= ~half_tgl;
      sel_slow <= chain_sel;
      scan_out <= out_fast;
    end
  end

  // fast domain: synchronizer, edge reference, select copy
  always_ff @(posedge fast_clk or posedge rst) begin
    if (rst) begin
      sync_q   <= '0;
      edge_ref <= 1'b0;
      sel_fast <= '0;
    end else begin
      sync_q   <= {sync_q[SYNC-2:0], half_tgl};
      edge_ref <= sync_q[SYNC-1];
      sel_fast <= sel_slow;
    end
  end

  assign capture_pulse = sync_q[SYNC-1] ^ edge_ref;

  always_comb begin
    head_bit = 1'b0;
    for (int c = 0; c < NCHAIN; c++)
      if (sel_fast == SW'(c)) head_bit = chain_state[c*LEN];
  end

  always_ff @(posedge fast_clk or posedge rst) begin
    if (rst)                out_fast <= 1'b0;
    else if (capture_pulse) out_fast <= head_bit;
  end

  for (genvar c = 0; c < NCHAIN; c++) begin : g_chain
    logic [LEN-1:0] bits_q;
    logic           hit;
    assign hit = capture_pulse && (sel_fast == SW'(c));
    always_ff @(posedge fast_clk or posedge rst) begin
      if (rst)      bits_q <= '0;
      else if (hit) bits_q <= {scan_in, bits_q[LEN-1:1]};
    end
    assign chain_state[c*LEN +: LEN] = bits_q;
  end
endmodule

module scan_shift_bridge_chk #(
  parameter int NCHAIN = 4,
  parameter int LEN    = 8
) (
  input logic                      fast_clk,
  input logic                      rst,
  input logic                      capture_pulse,
  input logic                      scan_in,
  input logic [$clog2(NCHAIN)-1:0] sel_fast,
  input logic                      out_fast,
  input logic [NCHAIN*LEN-1:0]     chain_state
);
  a_r2_single_cycle_pulse: assert property (@(posedge fast_clk) disable iff (rst)
    capture_pulse |=> !capture_pulse);

  a_r5_chains_hold: assert property (@(posedge fast_clk) disable iff (rst)
    !capture_pulse |=> $stable(chain_state));

  a_r6_out_hold: assert property (@(posedge fast_clk) disable iff (rst)
    !capture_pulse |=> $stable(out_fast));

  a_r4_msb_fill: assert property (@(posedge fast_clk) disable iff (rst)
    (capture_pulse && sel_fast == '0) |=> (chain_state[LEN-1] == $past(scan_in)));
endmodule

bind scan_shift_bridge scan_shift_bridge_chk #(.NCHAIN(NCHAIN), .LEN(LEN)) u_chk (
  .fast_clk(fast_clk),
  .rst(rst),
  .capture_pulse(capture_pulse),
  .scan_in(scan_in),
  .sel_fast(sel_fast),
  .out_fast(out_fast),
  .chain_state(chain_state)
);

// File: tb/scan_shift_bridge_test.sv
module scan_shift_bridge_test;
  localparam int FAST_T = 10;
  localparam int SLOW_T = 10 * FAST_T;
  localparam int NCHAIN = 4;
  localparam int LEN    = 8;
  localparam int SW     = $clog2(NCHAIN);

  logic fclk = 1'b0, sclk = 1'b0, rst = 1'b1;
  logic shift_req = 1'b0, scan_in = 1'b0;
  logic [SW-1:0] chain_sel = '0;
  logic scan_out, capture_pulse;
  logic [NCHAIN*LEN-1:0] chain_state;

  int checks = 0, errors = 0;
  logic [LEN-1:0] m [NCHAIN];
  logic exp_out = 1'b0;

  scan_shift_bridge #(.NCHAIN(NCHAIN), .LEN(LEN)) uut (
    .slow_clk(sclk), .fast_clk(fclk), .rst(rst),
    .shift_req(shift_req), .scan_in(scan_in), .chain_sel(chain_sel),
    .scan_out(scan_out), .capture_pulse(capture_pulse), .chain_state(chain_state)
  );

  always #(FAST_T/2) fclk = ~fclk;
  always #(SLOW_T/2) sclk = ~sclk;

  function automatic logic [NCHAIN*LEN-1:0] flat();
    logic [NCHAIN*LEN-1:0] v;
    for (int c = 0; c < NCHAIN; c++) v[c*LEN +: LEN] = m[c];
    return v;
  endfunction

  function automatic logic [LEN-1:0] shifted(logic [LEN-1:0] v, logic b);
    return {b, v[LEN-1:1]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one slow period; samples after 3rd and 4th fast edge past the slow edge
  task automatic step(input logic en, input logic b, input int sel);
    @(negedge sclk);
    shift_req = en; scan_in = b; chain_sel = SW'(sel);
    @(posedge sclk);
    #31;
    check(scan_out == exp_out, "R6 scan_out", 64'(scan_out), 64'(exp_out));
    check(capture_pulse == en, "R2 R3 pulse after 3rd edge", 64'(capture_pulse), 64'(en));
    check(chain_state == flat(), "R3 chain unchanged before 4th edge", 64'(chain_state), 64'(flat()));
    if (en) begin
      exp_out = m[sel][0];
      m[sel] = shifted(m[sel], b);
    end
    #10;
    check(capture_pulse == 1'b0, "R2 pulse one cycle", 64'(capture_pulse), 64'd0);
    check(chain_state == flat(), "R4 R5 R7 chain after capture", 64'(chain_state), 64'(flat()));
  endtask

  initial begin
    #(FAST_T * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCHAIN; c++) m[c] = '0;
    void'($urandom(32'd4242));
    #120;
    check(chain_state == '0 && scan_out == 1'b0 && capture_pulse == 1'b0,
          "R1 during reset", 64'(chain_state), 64'd0);
    #112 rst = 1'b0;
    #8;
    check(chain_state == '0 && scan_out == 1'b0 && capture_pulse == 1'b0,
          "R1 after release", 64'(chain_state), 64'd0);
    // R2: idle periods produce nothing
    step(1'b0, 1'b1, 0);
    step(1'b0, 1'b0, 1);
    // R4 R8: back-to-back fill of chain 0
    for (int i = 0; i < LEN; i++) step(1'b1, logic'(i % 2), 0);
    // R7: switch to chain 2 and fill with ones; R5 others unchanged
    for (int i = 0; i < LEN; i++) step(1'b1, 1'b1, 2);
    // R6: drain chain 0 through scan_out
    for (int i = 0; i < LEN; i++) step(1'b1, 1'b0, 0);
    step(1'b0, 1'b0, 0);
    // R7: alternate chains on consecutive shifts
    for (int i = 0; i < 8; i++) step(1'b1, logic'(i / 2 % 2), i % NCHAIN);
    // random mix
    for (int i = 0; i < 150; i++)
      step(logic'($urandom % 2), logic'($urandom % 2), int'($urandom % NCHAIN));
    step(1'b0, 1'b0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule